// File: doc/BRIEF.md
# Chained Eight-Way Priority Encoder, 32-Request Build

This block takes a bank of active-low request lines and reports which one has the highest number. It is made from identical eight-request stages. Each stage has three active-low outputs: a code, a "found" flag and an "idle" flag. A stage only works while its active-low enable is low. A stage that is enabled and sees no request drives its idle flag low. That idle flag is the enable of the stage that holds the next eight lower-numbered requests. Through this chain, a request in a higher group masks every request in the lower groups.

The top level links four stages into a 32-request encoder. Its combinational outputs are an active-high 5-bit winner index, one combined active-low found flag, and the idle flag of the lowest stage. The enable of the top stage is a port. Tie it low for standalone use, or drive it from the idle flag of a wider encoder above this one.

The block has no clock and no state. Every output follows its inputs within the same cycle.

Top module: `prio_enc32`

## Requirements
- R1: While `en_n` is low and at least one bit of `req_n` is low, `grant_idx` holds the highest bit position i for which `req_n[i]` is 0. Bit i of `req_n` is request i, and a request is asserted when its bit is 0.
- R2: `found_n` is 0 exactly when `en_n` is 0 and at least one `req_n` bit is 0.
- R3: `idle_n` is 0 exactly when `en_n` is 0 and every `req_n` bit is 1.
- R4: While `en_n` is 1, `found_n` and `idle_n` are both 1 and `grant_idx` is 0, whatever `req_n` holds.
- R5: While `en_n` is 0 and no request is asserted, `grant_idx` is 0 and `found_n` is 1.
- R6: `grant_idx[4:3]` equals the group number g of the winning request, where group g holds requests 8g to 8g+7. `grant_idx[2:0]` is the winner's position within that group.
- R7: A request in a higher group masks every request in the lower groups. A lower group's requests decide the index only when all higher groups are idle.
- R8: `found_n` and `idle_n` are never 0 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_n | input | 32 | Request lines, active low; bit i is request i |
| en_n | input | 1 | Enable of the top stage, active low |
| grant_idx | output | 5 | Number of the highest asserted request, active high |
| found_n | output | 1 | Low when enabled and any request is asserted |
| idle_n | output | 1 | Low when enabled and no request is asserted; enables a lower chain |

## Verification
The block holds no internal state. A fault inside it shows up on the ports in the same cycle as the input pattern that exposes it.

A broken enable link between stages shows up as a wrong group number in `grant_idx[4:3]`, or as a missing `found_n`. This only appears when the winning request sits below the break. Requests are therefore placed in every group, and in several groups at once.

A mistake in a stage's code shows in `grant_idx[2:0]`. A mistake in the idle logic shows on `idle_n`, or as two groups reporting a request at the same time.

// File: rtl/prio_pkg.sv
package prio_pkg;
    localparam int DEF_STAGE_W = 8;
    localparam int DEF_NSTAGE  = 4;
endpackage

// File: rtl/prio_stage.sv
module prio_stage #(
    parameter int W = 8,
    localparam int CW = $clog2(W)
) (
    input  logic [W-1:0]  req_n,
    input  logic          en_n,
    output logic [CW-1:0] code_n,
    output logic          gs_n,
    output logic          eo_n
);
    logic [CW-1:0] win;
    logic          hit;

    // Ascending scan: a later (higher) request overwrites the earlier one.
    always_comb begin
        win = '0;
        hit = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (!req_n[i]) begin
                win = CW'(i);
                hit = 1'b1;
            end
        end
    end

    always_comb begin
        code_n = (!en_n && hit) ? ~win : '1;
        gs_n   = !(!en_n && hit);
        eo_n   = !(!en_n && !hit);
    end
endmodule

// File: rtl/prio_merge.sv
module prio_merge #(
    parameter int NS = 4,
    parameter int CW = 3,
    localparam int SW = $clog2(NS)
) (
    input  logic [NS-1:0][CW-1:0] code_n,
    input  logic [NS-1:0]         gs_n,
    output logic [SW+CW-1:0]      idx,
    output logic                  found_n
);
    logic [SW-1:0] grp;
    logic [CW-1:0] low;

    // At most one stage reports a request, so OR-merging is exact.
    always_comb begin
        grp = '0;
        low = '0;
        for (int s = 0; s < NS; s++) begin
            if (!gs_n[s]) grp = grp | SW'(s);
            low = low | ~code_n[s];
        end
        idx     = {grp, low};
        found_n = &gs_n;
    end
endmodule

// File: rtl/prio_enc32.sv
module prio_enc32
    import prio_pkg::*;
#(
    parameter int NSTAGE  = DEF_NSTAGE,
    parameter int STAGE_W = DEF_STAGE_W,
    localparam int NREQ = NSTAGE * STAGE_W,
    localparam int CW   = $clog2(STAGE_W),
    localparam int IW   = $clog2(NSTAGE) + CW
) (
    input  logic [NREQ-1:0] req_n,
    input  logic            en_n,
    output logic [IW-1:0]   grant_idx,
    output logic            found_n,
    output logic            idle_n
);
    logic [NSTAGE-1:0][CW-1:0] st_code_n;
    logic [NSTAGE-1:0]         st_gs_n;
    logic [NSTAGE-1:0]         st_eo_n;
    logic [NSTAGE-1:0]         st_en_n;

    generate
        for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
            if (g == NSTAGE - 1) begin : g_head
                assign st_en_n[g] = en_n;
            end else begin : g_link
                assign st_en_n[g] = st_eo_n[g+1];
            end
            prio_stage #(.W(STAGE_W)) u_stage (
                .req_n  (req_n[g*STAGE_W +: STAGE_W]),
                .en_n   (st_en_n[g]),
                .code_n (st_code_n[g]),
                .gs_n   (st_gs_n[g]),
                .eo_n   (st_eo_n[g])
            );
        end
    endgenerate

    prio_merge #(.NS(NSTAGE), .CW(CW)) u_merge (
        .code_n  (st_code_n),
        .gs_n    (st_gs_n),
        .idx     (grant_idx),
        .found_n (found_n)
    );

    assign idle_n = st_eo_n[0];
endmodule

// File: rtl/prio_enc32_chk.sv
module prio_enc32_chk #(
    parameter int NSTAGE  = 4,
    parameter int STAGE_W = 8,
    localparam int NREQ = NSTAGE * STAGE_W,
    localparam int IW   = $clog2(NSTAGE) + $clog2(STAGE_W)
) (
    input logic [NREQ-1:0] req_n,
    input logic            en_n,
    input logic [IW-1:0]   grant_idx,
    input logic            found_n,
    input logic            idle_n
);
    logic above_clear;

    always_comb begin
        assert_exclusive_R8: assert (found_n || idle_n)
            else $error("found_n and idle_n both low");
        if (en_n) begin
            assert_disable_R4: assert (found_n && idle_n && grant_idx == '0)
                else $error("outputs active while disabled");
        end else begin
            assert_found_R2: assert (found_n == (&req_n))
                else $error("found_n disagrees with requests");
            assert_idle_R3: assert (idle_n == !(&req_n))
                else $error("idle_n disagrees with requests");
        end
        above_clear = 1'b1;
        for (int i = 0; i < NREQ; i++) begin
            if (i > int'(grant_idx) && !req_n[i]) above_clear = 1'b0;
        end
        if (!found_n) begin
            assert_winner_R1: assert (!req_n[grant_idx] && above_clear)
                else $error("winner is not the highest request");
        end
    end
endmodule

bind prio_enc32 prio_enc32_chk #(.NSTAGE(NSTAGE), .STAGE_W(STAGE_W)) u_chk (.*);

// File: tb/prio_enc32_bench.sv
module prio_enc32_bench;
    logic        clk = 1'b0;
    logic [31:0] req_n = '1;
    logic        en_n = 1'b1;
    logic [4:0]  grant_idx;
    logic        found_n;
    logic        idle_n;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    prio_enc32 u_prio_enc32 (
        .req_n     (req_n),
        .en_n      (en_n),
        .grant_idx (grant_idx),
        .found_n   (found_n),
        .idle_n    (idle_n)
    );

    function automatic logic [4:0] ref_idx(input logic [31:0] r, input logic e);
        if (e) return 5'd0;
        for (int i = 31; i >= 0; i--) if (!r[i]) return 5'(i);
        return 5'd0;
    endfunction

    function automatic logic ref_found(input logic [31:0] r, input logic e);
        return !(!e && !(&r));
    endfunction

    function automatic logic ref_idle(input logic [31:0] r, input logic e);
        return !(!e && (&r));
    endfunction

    task automatic check(input string tag, input logic [31:0] r, input logic e);
        @(negedge clk);
        req_n = r;
        en_n  = e;
        @(posedge clk);
        #1;
        n_chk++;
        if (grant_idx !== ref_idx(r, e)) begin
            n_fail++;
            $display("FAIL %s index: req_n=%h en_n=%b got %0d expected %0d",
                     tag, r, e, grant_idx, ref_idx(r, e));
        end
        n_chk++;
        if (found_n !== ref_found(r, e)) begin
            n_fail++;
            $display("FAIL %s found_n: req_n=%h en_n=%b got %b expected %b",
                     tag, r, e, found_n, ref_found(r, e));
        end
        n_chk++;
        if (idle_n !== ref_idle(r, e)) begin
            n_fail++;
            $display("FAIL %s idle_n: req_n=%h en_n=%b got %b expected %b",
                     tag, r, e, idle_n, ref_idle(r, e));
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd1234));
        // R4: initial disabled, idle state
        check("R4 start", 32'hFFFF_FFFF, 1'b1);
        // R5, R3: enabled, nothing requested
        check("R5 R3 none", 32'hFFFF_FFFF, 1'b0);
        // R1, R6: every single request
        for (int i = 0; i < 32; i++) check("R1 R6 single", ~(32'd1 << i), 1'b0);
        // R7: all requests, and both ends of adjacent groups
        check("R7 all", 32'h0000_0000, 1'b0);
        check("R7 bits0_31", ~32'h8000_0001, 1'b0);
        check("R7 bits7_8", ~32'h0000_0180, 1'b0);
        check("R7 bits15_16", ~32'h0001_8000, 1'b0);
        check("R7 bits23_24", ~32'h0180_0000, 1'b0);
        // R4: requests present but disabled
        for (int k = 0; k < 20; k++) check("R4 disabled", $urandom(), 1'b1);
        // R1 R2 R7 R8: random patterns across groups
        for (int k = 0; k < 400; k++) begin
            r = $urandom() | $urandom();
            if (k % 4 == 1) r = r | 32'hFF00_0000;
            if (k % 4 == 2) r = r | 32'hFFFF_0000;
            if (k % 4 == 3) r = r | 32'hFFFF_FF00;
            check("R1 R2 R7 R8 random", r, 1'b0);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule